// File: doc/BRIEF.md
# NAND flash command sequencer

This block runs one raw NAND flash operation each time a host starts it. The host first writes the address, byte count and optional second opcode into a small register file. It then writes a control word whose top bit starts the operation. The control word also carries the first opcode, the data direction, the number of address cycles and the chip select.

The sequencer then drives the flash strobes through a fixed order of phases:

1. The first opcode, with CLE high.
2. The address bytes, with ALE high, least significant byte first.
3. Write data taken from a byte FIFO, when the operation writes.
4. A second opcode, when one is enabled.
5. A settle wait, followed by a wait for the flash ready line.
6. Read data pushed into a byte FIFO, when the operation reads.

When the operation completes, interrupt flags are set and stay set until the host clears them.

Every flash strobe phase lasts a fixed number of clock cycles, set by parameters. A write-enable pulse and a read-enable pulse each hold low for `T_LOW` cycles and then high for `T_HIGH` cycles. After the last write strobe of an operation, the block always waits `TWB_CYCLES` cycles before it trusts the ready line.

Top module: `nand_seq_top`

## Requirements
- R1: Writing register 0 with bit 31 set while the block is idle starts an operation. Status register 6 bit 0 (busy) reads 1 from the next cycle until completion. The first flash strobe is a write pulse with CLE high, ALE low, and control bits 7:0 on the data lines.
- R2: When control bit 30 is set, the first opcode is followed by (bits 29:27)+1 write pulses with ALE high. Their bytes are taken in this order: register 2 bits 7:0, register 2 bits 15:8, then register 3 bytes 0 to 3, and then zero. When bit 30 is clear, no ALE pulse is issued.
- R3: When control bit 25 is set, exactly N write pulses carry FIFO bytes after the address phase, where N is the value in register 4. There is one `txPop` per byte. Interrupt bit 28 is set once the data has been sent.
- R4: When control bit 26 is set and bit 25 is clear, no read pulse is issued before the ready line is high. The block then issues exactly N read pulses and presents one `rxPush` per byte while read-enable is low. Interrupt bit 28 is set.
- R5: When register 1 bit 8 was set at start, the opcode in register 1 bits 7:0 is sent with CLE high. It follows the address bytes and any write data, and it is the last write pulse of the operation.
- R6: After the last write pulse, at least `TWB_CYCLES` cycles pass before completion. The block stays busy while the ready input is low. Status bit 30 mirrors the ready input.
- R7: Completion sets interrupt register 5 bit 31, and `irqPending` is high while bit 31 or bit 28 is set. Writing 1 to a bit of register 5 clears it.
- R8: During an operation, control bit 19 set drives `nandCeN` to 2'b01 and bit 19 clear drives it to 2'b10. The value stays constant for the whole operation and is 2'b11 when idle.
- R9: While busy, writes to registers 0 to 4 are ignored, including a new start: the register readback is unchanged and no second operation follows.
- R10: A data direction with a count of 0 issues no data strobes and leaves interrupt bit 28 clear.
- R11: A read with a single address cycle and ready already high, as used for identification and status reads, completes without hanging.
- R12: CLE and ALE are never high together, and write-enable and read-enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 3 | Register index for writes |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 3 | Register index for reads |
| regRdData | output | 32 | Register read data (combinational) |
| irqPending | output | 1 | High while any interrupt flag is set |
| nandCeN | output | 2 | Active-low chip enables |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Active-low write enable |
| nandReN | output | 1 | Active-low read enable |
| nandDqOut | output | 8 | Data lines toward the flash |
| nandDqOe | output | 1 | Drive enable for the data lines |
| nandDqIn | input | 8 | Data lines from the flash |
| nandRb | input | 1 | Flash ready (high) / busy (low) |
| txData | input | 8 | Head byte of the write FIFO |
| txPop | output | 1 | Consume the write FIFO head |
| rxData | output | 8 | Byte for the read FIFO |
| rxPush | output | 1 | Push `rxData` into the read FIFO |

## Verification
The assertions take two things for granted about the inputs. First, the host never sets both data-direction bits in the same control word. Second, the write FIFO always has a byte whenever `txPop` fires, because the block does not look at any FIFO level. The stimulus sets at most one direction bit per operation. It serves write bytes from a free-running counter that is always available. It also holds the ready line low for a set number of cycles after each start, so that the ready wait is exercised in a known window.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // register indices
  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_CTRL2  = 3'd1;
  localparam logic [2:0] REG_ADDRLO = 3'd2;
  localparam logic [2:0] REG_ADDRHI = 3'd3;
  localparam logic [2:0] REG_LEN    = 3'd4;
  localparam logic [2:0] REG_IRQ    = 3'd5;
  localparam logic [2:0] REG_STAT   = 3'd6;

  // control word bit positions
  localparam int B_START = 31;
  localparam int B_HASADDR = 30;
  localparam int B_RD = 26;
  localparam int B_WR = 25;
  localparam int B_CS = 19;
  localparam int B_CMD2EN = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_TWB, S_WAITRB, S_RDATA, S_FINISH
  } seqState_t;

  typedef enum logic [1:0] {DQ_CMD1, DQ_ADDR, DQ_DATA, DQ_CMD2} dqSel_t;

  // control -> datapath
  typedef struct packed {
    logic   shAddr;
    logic   decCnt;
    logic   popTx;
    logic   pushRx;
    logic   setDone;
    logic   setXfer;
    dqSel_t dqSel;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic start;
    logic hasAddr;
    logic isRd;
    logic isWr;
    logic cmd2En;
    logic lenZero;
    logic lenLast;
    logic addrLast;
    logic chipSel;
  } opInfo_t;

endpackage

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [2:0]  rdAddr,
  output logic [31:0] rdData,
  input  logic        busy,
  input  logic        nandRb,
  input  seqStrobe_t  strobe,
  output opInfo_t     info,
  output logic [7:0]  dqOut,
  input  logic [7:0]  txData,
  output logic        irqPending
);

  localparam int ADDR_BYTES = 6;
  localparam int SHIFT_W = ADDR_BYTES * 8;

  logic [31:0]        ctrlWord, ctrl2Word, addrHiReg;
  logic [15:0]        addrLoReg;
  logic [LEN_W-1:0]   lenReg, byteCnt;
  logic [SHIFT_W-1:0] addrShift;
  logic [3:0]         addrLeft;
  logic [7:0]         cmd2Op;
  logic               cmd2On, irqDone, irqXfer;
  logic               startReq, cfgWr, clrDone, clrXfer;

  assign cfgWr    = wrEn && !busy;
  assign startReq = cfgWr && (wrAddr == REG_CTRL) && wrData[B_START];
  assign clrDone  = wrEn && (wrAddr == REG_IRQ) && wrData[31];
  assign clrXfer  = wrEn && (wrAddr == REG_IRQ) && wrData[28];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord  <= '0;
      ctrl2Word <= '0;
      addrLoReg <= '0;
      addrHiReg <= '0;
      lenReg    <= '0;
      addrShift <= '0;
      addrLeft  <= '0;
      byteCnt   <= '0;
      cmd2Op    <= '0;
      cmd2On    <= 1'b0;
      irqDone   <= 1'b0;
      irqXfer   <= 1'b0;
    end else begin
      if (cfgWr) begin
        case (wrAddr)
          REG_CTRL:   ctrlWord  <= wrData;
          REG_CTRL2:  ctrl2Word <= wrData;
          REG_ADDRLO: addrLoReg <= wrData[15:0];
          REG_ADDRHI: addrHiReg <= wrData;
          REG_LEN:    lenReg    <= wrData[LEN_W-1:0];
          default: ;
        endcase
      end
      if (startReq) begin
        addrShift <= {addrHiReg, addrLoReg};
        addrLeft  <= {1'b0, wrData[29:27]} + 4'd1;
        byteCnt   <= lenReg;
        cmd2Op    <= ctrl2Word[7:0];
        cmd2On    <= ctrl2Word[B_CMD2EN];
      end else begin
        if (strobe.shAddr) begin
          addrShift <= addrShift >> 8;
          addrLeft  <= addrLeft - 4'd1;
        end
        if (strobe.decCnt) byteCnt <= byteCnt - 1'b1;
      end
      // set wins over a same-cycle clear
      irqDone <= strobe.setDone | (irqDone & ~clrDone);
      irqXfer <= strobe.setXfer | (irqXfer & ~clrXfer);
    end
  end

  always_comb begin
    info.start    = startReq;
    info.hasAddr  = ctrlWord[B_HASADDR];
    info.isWr     = ctrlWord[B_WR];
    info.isRd     = ctrlWord[B_RD] & ~ctrlWord[B_WR];
    info.cmd2En   = cmd2On;
    info.lenZero  = (byteCnt == '0);
    info.lenLast  = (byteCnt == LEN_W'(1));
    info.addrLast = (addrLeft == 4'd1);
    info.chipSel  = ctrlWord[B_CS];
  end

  always_comb begin
    case (strobe.dqSel)
      DQ_CMD1: dqOut = ctrlWord[7:0];
      DQ_ADDR: dqOut = addrShift[7:0];
      DQ_DATA: dqOut = txData;
      default: dqOut = cmd2Op;
    endcase
  end

  always_comb begin
    case (rdAddr)
      REG_CTRL:   rdData = ctrlWord;
      REG_CTRL2:  rdData = ctrl2Word;
      REG_ADDRLO: rdData = {16'b0, addrLoReg};
      REG_ADDRHI: rdData = addrHiReg;
      REG_LEN:    rdData = 32'(lenReg);
      REG_IRQ:    rdData = {irqDone, 2'b0, irqXfer, 28'b0};
      REG_STAT:   rdData = {1'b0, nandRb, 29'b0, busy};
      default:    rdData = '0;
    endcase
  end

  assign irqPending = irqDone | irqXfer;

endmodule

// File: rtl/nand_seq_ctl.sv
module nand_seq_ctl
  import nand_seq_pkg::*;
#(
  parameter int T_LOW      = 2,
  parameter int T_HIGH     = 2,
  parameter int TWB_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  opInfo_t    info,
  input  logic       nandRb,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       cle,
  output logic       ale,
  output logic       weN,
  output logic       reN,
  output logic       dqOe,
  output logic [1:0] ceN
);

  localparam int BYTE_TICKS = T_LOW + T_HIGH;
  localparam int TICK_W = $clog2(BYTE_TICKS + 1);
  localparam int WB_W = $clog2(TWB_CYCLES + 1);

  seqState_t state, nextState;
  logic [TICK_W-1:0] tick;
  logic [WB_W-1:0]   wbCnt;
  logic byteState, writeState, byteDone;
  seqState_t afterAddr, afterData;

  assign writeState = (state == S_CMD1) || (state == S_ADDR) ||
                      (state == S_WDATA) || (state == S_CMD2);
  assign byteState  = writeState || (state == S_RDATA);
  assign byteDone   = byteState && (tick == TICK_W'(BYTE_TICKS - 1));

  assign afterData = info.cmd2En ? S_CMD2 : S_TWB;
  assign afterAddr = (info.isWr && !info.lenZero) ? S_WDATA : afterData;

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE:   if (info.start) nextState = S_CMD1;
      S_CMD1:   if (byteDone) nextState = info.hasAddr ? S_ADDR : afterAddr;
      S_ADDR:   if (byteDone && info.addrLast) nextState = afterAddr;
      S_WDATA:  if (byteDone && info.lenLast) nextState = afterData;
      S_CMD2:   if (byteDone) nextState = S_TWB;
      S_TWB:    if (wbCnt == WB_W'(TWB_CYCLES - 1)) nextState = S_WAITRB;
      S_WAITRB: if (nandRb) nextState = (info.isRd && !info.lenZero) ? S_RDATA : S_FINISH;
      S_RDATA:  if (byteDone && info.lenLast) nextState = S_FINISH;
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      tick  <= '0;
      wbCnt <= '0;
    end else begin
      state <= nextState;
      tick  <= (byteDone || !byteState) ? '0 : tick + 1'b1;
      wbCnt <= (state == S_TWB) ? wbCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    strobe.shAddr  = (state == S_ADDR) && byteDone;
    strobe.decCnt  = ((state == S_WDATA) || (state == S_RDATA)) && byteDone;
    strobe.popTx   = (state == S_WDATA) && byteDone;
    strobe.pushRx  = (state == S_RDATA) && (tick == TICK_W'(T_LOW - 1));
    strobe.setXfer = strobe.decCnt && info.lenLast;
    strobe.setDone = (state == S_FINISH);
    case (state)
      S_ADDR:  strobe.dqSel = DQ_ADDR;
      S_WDATA: strobe.dqSel = DQ_DATA;
      S_CMD2:  strobe.dqSel = DQ_CMD2;
      default: strobe.dqSel = DQ_CMD1;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign cle  = (state == S_CMD1) || (state == S_CMD2);
  assign ale  = (state == S_ADDR);
  assign weN  = !(writeState && (tick < TICK_W'(T_LOW)));
  assign reN  = !((state == S_RDATA) && (tick < TICK_W'(T_LOW)));
  assign dqOe = writeState;
  assign ceN  = !busy ? 2'b11 : (info.chipSel ? 2'b01 : 2'b10);

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int T_LOW      = 2,
  parameter int T_HIGH     = 2,
  parameter int TWB_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regWrAddr,
  input  logic [31:0] regWrData,
  input  logic [2:0]  regRdAddr,
  output logic [31:0] regRdData,
  output logic        irqPending,
  output logic [1:0]  nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic [7:0]  nandDqOut,
  output logic        nandDqOe,
  input  logic [7:0]  nandDqIn,
  input  logic        nandRb,
  input  logic [7:0]  txData,
  output logic        txPop,
  output logic [7:0]  rxData,
  output logic        rxPush
);

  seqStrobe_t strobe;
  opInfo_t    info;
  logic       busy;

  nand_seq_dp #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrEn), .wrAddr(regWrAddr), .wrData(regWrData),
    .rdAddr(regRdAddr), .rdData(regRdData),
    .busy(busy), .nandRb(nandRb), .strobe(strobe), .info(info),
    .dqOut(nandDqOut), .txData(txData), .irqPending(irqPending)
  );

  nand_seq_ctl #(.T_LOW(T_LOW), .T_HIGH(T_HIGH), .TWB_CYCLES(TWB_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .info(info), .nandRb(nandRb),
    .strobe(strobe), .busy(busy),
    .cle(nandCle), .ale(nandAle), .weN(nandWeN), .reN(nandReN),
    .dqOe(nandDqOe), .ceN(nandCeN)
  );

  assign txPop  = strobe.popTx;
  assign rxPush = strobe.pushRx;
  assign rxData = nandDqIn;

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       reN,
  input logic [1:0] ceN,
  input logic       rxPush,
  input logic       irqPending
);

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(cle && ale)); // R12
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(!weN && !reN)); // R12
  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(~ceN)); // R8
  AST_CE_STABLE: assert property (@(posedge clk) disable iff (!rstN) (busy && $past(busy)) |-> $stable(ceN)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !busy |-> (weN && reN && !cle && !ale)); // R1
  AST_RX_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN) rxPush |-> !reN); // R4
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> irqPending); // R7

endmodule

bind nand_seq_top nand_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .cle(nandCle), .ale(nandAle),
  .weN(nandWeN), .reN(nandReN), .ceN(nandCeN), .rxPush(rxPush),
  .irqPending(irqPending)
);

// File: tb/sim_nand_seq_top.sv
`timescale 1ns/1ps
module sim_nand_seq_top;

  localparam int TWB = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [2:0]  regRdAddr = 3'd6;
  logic [31:0] regRdData;
  logic        irqPending;
  logic [1:0]  nandCeN;
  logic        nandCle, nandAle, nandWeN, nandReN, nandDqOe;
  logic [7:0]  nandDqOut, nandDqIn, txData, rxData;
  logic        nandRb = 1'b1;
  logic        txPop, rxPush;

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  int cycNow = 0, lastWeCyc = 0;
  int logN = 0, rxN = 0, txCnt = 0, rdIdx = 0, pinViol = 0;
  bit prevWeN = 1, prevReN = 1;
  bit logCle[64], logAle[64];
  logic [7:0] logDq[64], rxLog[64];
  logic [1:0] logCe[64];

  always #2.5 clk = ~clk;

  assign nandDqIn = 8'h5A ^ rdIdx[7:0];
  assign txData = 8'hC3 + txCnt[7:0];

  nand_seq_top u0 (.*);

  // pin monitor, sampled away from the active edge
  always @(negedge clk) begin
    cycNow++;
    if (prevWeN == 0 && nandWeN == 1 && logN < 64) begin
      logCle[logN] = nandCle; logAle[logN] = nandAle;
      logDq[logN] = nandDqOut; logCe[logN] = nandCeN;
      logN++;
      lastWeCyc = cycNow;
    end
    prevWeN = nandWeN;
    if (prevReN == 0 && nandReN == 1) rdIdx++;
    prevReN = nandReN;
    if (rxPush && rxN < 64) begin rxLog[rxN] = rxData; rxN++; end
    if (txPop) txCnt++;
    if ((nandCle && nandAle) || (!nandWeN && !nandReN)) pinViol++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    regRdAddr = a; #1; d = regRdData; regRdAddr = 3'd6;
  endtask

  function automatic logic [7:0] addrByte(input logic [15:0] lo, input logic [31:0] hi, input int i);
    if (i < 2) return lo[8*i +: 8];
    if (i < 6) return hi[8*(i-2) +: 8];
    return 8'h00;
  endfunction

  // mode: 0 command only, 1 write, 2 read
  task automatic runOp(input int mode, input int aCyc, input int len, input bit c2,
                       input bit cs, input int hold, input bit intrude);
    logic [15:0] lo; logic [31:0] hi, ctrl, rv;
    logic [7:0] op1, op2;
    int cnt, k, doneCyc, reEarly;
    bit okA, okW, okC2, okCe, timedOut;
    lo = 16'hB7A1 ^ 16'(aCyc * 16'h0101);
    hi = 32'h6655_4433 + 32'(len);
    op1 = 8'h10 + 8'(mode * 16) + 8'(aCyc);
    op2 = 8'hE0 ^ 8'(aCyc);
    wrReg(3'd2, {16'hFFFF, lo});
    wrReg(3'd3, hi);
    wrReg(3'd4, 32'(len));
    wrReg(3'd1, {23'b0, c2, op2});
    ctrl = '0;
    ctrl[31] = 1'b1;
    ctrl[30] = (aCyc != 0);
    ctrl[29:27] = (aCyc != 0) ? 3'(aCyc - 1) : 3'd0;
    ctrl[26] = (mode == 2);
    ctrl[25] = (mode == 1);
    ctrl[19] = cs;
    ctrl[7:0] = op1;
    logN = 0; rxN = 0; txCnt = 0; rdIdx = 0; reEarly = 0;
    nandRb = 1'b0;
    wrReg(3'd0, ctrl);
    cnt = 0; timedOut = 0;
    forever begin
      cnt++;
      if (cnt == hold) begin nandRb = 1'b1; reEarly = rdIdx; end
      if (intrude && cnt == 40) begin
        regWrEn = 1'b1; regWrAddr = 3'd0; regWrData = 32'h8000_00FF;
      end
      if (intrude && cnt == 41) begin
        regWrEn = 1'b1; regWrAddr = 3'd4; regWrData = 32'd77;
      end
      if (intrude && cnt == 42) regWrEn = 1'b0;
      if (intrude && cnt == hold - 1) begin
        #1;
        chk(regRdData[0] == 1'b1 && irqPending == 1'b0, "R6 busy while not ready", regRdData[0], 1);
      end
      #1;
      if (cnt > 1 && regRdData[0] == 1'b0) break;
      if (cnt > 3000) begin timedOut = 1; break; end
      @(negedge clk);
    end
    doneCyc = cycNow;
    chk(!timedOut, "R11 operation completes", cnt, 0);
    // expected write-pulse sequence
    chk(logN > 0 && logCle[0] && !logAle[0] && logDq[0] == op1, "R1 first opcode", logDq[0], op1);
    k = 1; okA = 1; okW = 1; okC2 = 1; okCe = 1;
    for (int i = 0; i < aCyc; i++) begin
      if (!(k < logN && logAle[k] && !logCle[k] && logDq[k] == addrByte(lo, hi, i))) okA = 0;
      k++;
    end
    chk(okA, "R2 address bytes", aCyc, aCyc);
    if (mode == 1) begin
      for (int i = 0; i < len; i++) begin
        if (!(k < logN && !logAle[k] && !logCle[k] && logDq[k] == 8'hC3 + 8'(i))) okW = 0;
        k++;
      end
    end
    chk(okW && txCnt == ((mode == 1) ? len : 0), "R3 write data", txCnt, (mode == 1) ? len : 0);
    if (c2) begin
      if (!(k < logN && logCle[k] && logDq[k] == op2)) okC2 = 0;
      k++;
    end
    chk(okC2 && logN == k, "R5 second opcode and pulse count", logN, k);
    for (int i = 0; i < logN; i++) if (logCe[i] != (cs ? 2'b01 : 2'b10)) okCe = 0;
    chk(okCe && nandCeN == 2'b11, "R8 chip enable", nandCeN, 2'b11);
    chk(rxN == ((mode == 2) ? len : 0) && reEarly == 0, "R4 read count", rxN, (mode == 2) ? len : 0);
    for (int i = 0; i < rxN; i++)
      chk(rxLog[i] == (8'h5A ^ 8'(i)), "R4 read byte", rxLog[i], 8'h5A ^ 8'(i));
    chk(doneCyc - lastWeCyc >= TWB, "R6 settle wait", doneCyc - lastWeCyc, TWB);
    rdReg(3'd5, rv);
    chk(rv[31] == 1'b1 && irqPending, "R7 done flag", rv[31], 1);
    chk(rv[28] == (mode != 0 && len != 0), "R10 transfer flag", rv[28], (mode != 0 && len != 0));
    wrReg(3'd5, 32'h9000_0000);
    rdReg(3'd5, rv);
    chk(rv == 32'h0 && !irqPending, "R7 write-one clear", rv, 0);
    if (intrude) begin
      repeat (20) @(negedge clk);
      rdReg(3'd0, rv);
      chk(rv == ctrl, "R9 control ignored while busy", rv, ctrl);
      rdReg(3'd4, rv);
      chk(rv == 32'(len), "R9 length ignored while busy", rv, len);
      chk(regRdData[0] == 1'b0 && logN == k, "R9 no second operation", logN, k);
    end
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(regRdData[0] == 1'b0 && nandCeN == 2'b11 && nandWeN && nandReN && !irqPending,
        "R1 reset state", {regRdData[0], nandCeN}, 3'b011);
    chk(regRdData[30] == 1'b1, "R6 ready mirror high", regRdData[30], 1);
    nandRb = 1'b0; #1;
    chk(regRdData[30] == 1'b0, "R6 ready mirror low", regRdData[30], 0);
    nandRb = 1'b1;
    // identification-style and status-style reads: one address cycle, ready already high
    runOp(2, 1, 4, 0, 0, 1, 0);
    runOp(2, 1, 1, 0, 1, 1, 0);
    // long ready wait with writes landing mid-operation
    runOp(0, 3, 0, 1, 1, 150, 1);
    // sweep over direction, address cycles, length, second opcode, chip select
    for (int m = 0; m < 3; m++)
      for (int a = 0; a <= 8; a++)
        for (int l = 0; l < 3; l++)
          for (int c = 0; c < 2; c++)
            for (int s = 0; s < 2; s++)
              runOp(m, a, (l == 0) ? 0 : (l == 1) ? 1 : 5, c[0], s[0], 20, 0);
    chk(pinViol == 0, "R12 strobe exclusivity", pinViol, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule